// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block models a single-port synchronous static memory with a two-lane data path. Each lane is nine bits wide: eight data bits plus that byte's parity bit. Every control input is sampled on the rising clock edge.

An access starts when one of two address strobes is accepted while the device is selected. One strobe is meant for a processor and the other for a memory controller. The accepted strobe captures the full address. Its two lowest bits are loaded into a burst counter. While no strobe is asserted, each following edge continues the burst: the counter steps when the advance input is low, and holds otherwise. The upper address bits stay fixed for the whole burst.

Writes either update every lane through a global write input, or update selected lanes through a byte-write enable and per-lane selects. Read data is registered. An asynchronous output enable and a sleep input decide whether the data outputs are driven.

Top module: `burst_sram_top`

## Requirements
- R1: An edge with an accepted strobe while selN1=0, sel2=1 and selN3=0 starts an access at addrIn. Its low two bits load the burst counter and the device becomes active.
- R2: An accepted strobe on an edge where any of the three selects is inactive ends the burst. Later edges without a strobe then perform no access and rdDrive stays 0.
- R3: When strobeCpuN and strobeCtlN are both low and selN1=0, the processor strobe wins. An access started by the processor strobe is always a read, and the write inputs have no effect on that edge.
- R4: strobeCpuN is ignored while selN1=1. An edge with only that strobe low behaves like an edge with no strobe, so an active burst continues.
- R5: On an edge with no strobe during an active burst, advanceN=0 increments the burst counter modulo 4. The new value selects the low two address bits, and the upper bits keep the captured value.
- R6: On an edge with no strobe during an active burst, advanceN=1 repeats the access at the same address.
- R7: globalWrN=0 on a write-capable access writes both lanes, whatever byteWrEnN and laneSelN are.
- R8: With globalWrN=1 and byteWrEnN=0, each lane i with laneSelN[i]=0 is written. Lane 0 is wrData[8:0] and lane 1 is wrData[17:9], with bit 8 of each lane its parity bit. With byteWrEnN=1 the access is a read. After a write edge, rdDrive is 0.
- R9: After a read edge, rdData holds the word at that edge's effective address until the next read edge.
- R10: While outEnN=1 in the current cycle, rdDrive=0 and rdData=0.
- R11: The first read of an access begun from the inactive state is never driven. rdDrive=0 for that cycle, whatever outEnN is.
- R12: While sleep=1, edges change no state and no memory word, and rdDrive=0. Stored words and the burst position survive the sleep period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| addrIn | input | ADDR_W | Address, captured on an accepted strobe |
| selN1 | input | 1 | Select 1, active low; also gates the processor strobe |
| sel2 | input | 1 | Select 2, active high |
| selN3 | input | 1 | Select 3, active low |
| strobeCpuN | input | 1 | Processor address strobe, active low, higher priority |
| strobeCtlN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Byte write enable, active low |
| laneSelN | input | 2 | Per-lane write selects, active low |
| wrData | input | 18 | Write data, two 9-bit lanes |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high |
| rdData | output | 18 | Read data, zero when not driven |
| rdDrive | output | 1 | High when rdData is driven |

## Verification
The bench attacks the counter wrap from a start offset of 1, where a counter that carries into the upper bits would read a word four locations away. It drives both strobes together with a global write, which a design lacking processor priority would turn into a write. It asserts the processor strobe while selN1 is high, where a design without that gating would restart the burst. It also checks the first read after a deselect, which a design without masking would drive early. A long random phase with sleep periods follows, and it would expose state that changes while asleep.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES   = 2;
  localparam int LANE_W  = 9;
  localparam int BURST_W = 2;
  localparam int DATA_W  = LANES * LANE_W;

  typedef struct packed {
    logic               tick;      // edge is not asleep
    logic               access;    // an access happens this edge
    logic [LANES-1:0]   laneWr;    // lanes written this edge
    logic               doRead;    // read access this edge
    logic               loadBase;  // capture upper address bits
    logic [BURST_W-1:0] burstIdx;  // low address bits of this access
    logic               maskFirst; // suppress drive of current read word
  } ctrlStrobes_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selN1,
  input  logic                sel2,
  input  logic                selN3,
  input  logic                strobeCpuN,
  input  logic                strobeCtlN,
  input  logic                advanceN,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [LANES-1:0]    laneSelN,
  input  logic                sleep,
  input  logic [BURST_W-1:0]  lowAddr,
  output ctrlStrobes_t        strobes
);
  logic               activeQ, firstQ;
  logic [BURST_W-1:0] cntQ, cntNext;
  logic               selected, cpuSeen, ctlSeen, strobeSeen;
  logic               startAcc, contAcc, access, activeNext;
  logic [LANES-1:0]   laneReq, laneWr;

  assign selected   = !selN1 && sel2 && !selN3;
  assign cpuSeen    = !strobeCpuN && !selN1;
  assign ctlSeen    = !strobeCtlN && !cpuSeen;
  assign strobeSeen = cpuSeen || ctlSeen;
  assign startAcc   = strobeSeen && selected;
  assign contAcc    = !strobeSeen && activeQ;
  assign access     = !sleep && (startAcc || contAcc);

  always_comb begin
    if (startAcc)                 cntNext = lowAddr;
    else if (contAcc && !advanceN) cntNext = cntQ + BURST_W'(1);
    else                          cntNext = cntQ;
  end

  always_comb begin
    if (startAcc)        activeNext = 1'b1;
    else if (strobeSeen) activeNext = 1'b0;
    else                 activeNext = activeQ;
  end

  genvar li;
  generate
    for (li = 0; li < LANES; li++) begin : g_laneReq
      assign laneReq[li] = !globalWrN || (!byteWrEnN && !laneSelN[li]);
    end
  endgenerate

  assign laneWr = (access && !cpuSeen) ? laneReq : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      cntQ    <= '0;
      firstQ  <= 1'b1;
    end else if (!sleep) begin
      activeQ <= activeNext;
      cntQ    <= cntNext;
      if (access && laneWr == '0) firstQ <= !activeQ;
    end
  end

  always_comb begin
    strobes.tick      = !sleep;
    strobes.access    = access;
    strobes.laneWr    = laneWr;
    strobes.doRead    = access && (laneWr == '0);
    strobes.loadBase  = startAcc;
    strobes.burstIdx  = cntNext;
    strobes.maskFirst = firstQ;
  end

  // R1
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && startAcc) |=> (activeQ && cntQ == $past(lowAddr)));
  // R2
  deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && strobeSeen && !selected) |=> !activeQ);
  // R5
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && contAcc && !advanceN) |=> cntQ == $past(cntQ) + BURST_W'(1));
  // R12
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(cntQ) && $stable(activeQ)));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               outEnN,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdDrive
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int UP_W  = ADDR_W - BURST_W;

  logic [UP_W-1:0]   baseQ, effUpper;
  logic [ADDR_W-1:0] effAddr;
  logic              rdValidQ;
  logic [DATA_W-1:0] rdRegAll;

  assign effUpper = strobes.loadBase ? addrIn[ADDR_W-1:BURST_W] : baseQ;
  assign effAddr  = {effUpper, strobes.burstIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ    <= '0;
      rdValidQ <= 1'b0;
    end else if (strobes.tick) begin
      if (strobes.loadBase) baseQ <= addrIn[ADDR_W-1:BURST_W];
      rdValidQ <= strobes.doRead;
    end
  end

  genvar li;
  generate
    for (li = 0; li < LANES; li++) begin : g_lane
      logic [LANE_W-1:0] laneMem [DEPTH];
      logic [LANE_W-1:0] laneRd;
      always_ff @(posedge clk) begin
        if (strobes.tick && strobes.laneWr[li])
          laneMem[effAddr] <= wrData[li*LANE_W +: LANE_W];
        if (strobes.tick && strobes.doRead)
          laneRd <= laneMem[effAddr];
      end
      assign rdRegAll[li*LANE_W +: LANE_W] = laneRd;
    end
  endgenerate

  assign rdDrive = rdValidQ && !strobes.maskFirst && !outEnN && strobes.tick;
  assign rdData  = rdDrive ? rdRegAll : '0;

  // R8
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && strobes.access && strobes.laneWr != '0) |=> !rdValidQ);
  // R11
  first_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskFirst |-> (rdData == '0));
  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !rdDrive);
endmodule

// File: rtl/burst_sram_top.sv
module burst_sram_top
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                selN1,
  input  logic                sel2,
  input  logic                selN3,
  input  logic                strobeCpuN,
  input  logic                strobeCtlN,
  input  logic                advanceN,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [LANES-1:0]    laneSelN,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                outEnN,
  input  logic                sleep,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdDrive
);
  ctrlStrobes_t strobes;

  sram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .selN1(selN1), .sel2(sel2), .selN3(selN3),
    .strobeCpuN(strobeCpuN), .strobeCtlN(strobeCtlN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneSelN(laneSelN),
    .sleep(sleep), .lowAddr(addrIn[BURST_W-1:0]), .strobes(strobes)
  );

  sram_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrIn(addrIn),
    .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: tb/burst_sram_top_tb.sv
module burst_sram_top_tb_top;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN;
  logic [ADDR_W-1:0] addrIn;
  logic selN1, sel2, selN3, strobeCpuN, strobeCtlN, advanceN;
  logic globalWrN, byteWrEnN, outEnN, sleep;
  logic [1:0]  laneSelN;
  logic [17:0] wrData, rdData;
  logic        rdDrive;

  always #2.5 clk = ~clk;

  burst_sram_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selN1(selN1), .sel2(sel2),
    .selN3(selN3), .strobeCpuN(strobeCpuN), .strobeCtlN(strobeCtlN),
    .advanceN(advanceN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneSelN(laneSelN), .wrData(wrData), .outEnN(outEnN), .sleep(sleep),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  // behavioural reference state
  logic [17:0] refMem [int];
  bit          mActive, mValid, mFirst;
  int          mCnt, mBase;
  logic [17:0] mRd;
  int          vectors = 0, misses = 0;
  string       tag = "R2";
  bit          finished = 0;

  task automatic modelStep();
    bit sel, cpu, ctl, acc, wasActive;
    int eff;
    logic [1:0] lanes;
    if (!rstN) begin
      mActive = 0; mValid = 0; mFirst = 1; mCnt = 0; mBase = 0;
      return;
    end
    if (sleep) return;
    sel = !selN1 && sel2 && !selN3;
    cpu = !strobeCpuN && !selN1;
    ctl = !strobeCtlN && !cpu;
    wasActive = mActive;
    acc = 0; eff = 0;
    if (cpu || ctl) begin
      if (sel) begin
        mBase = addrIn / 4; mCnt = addrIn % 4; acc = 1; mActive = 1;
      end else mActive = 0;
    end else if (mActive) begin
      if (!advanceN) mCnt = (mCnt + 1) % 4;
      acc = 1;
    end
    eff = mBase * 4 + mCnt;
    lanes = 2'b00;
    if (acc && !cpu)
      for (int i = 0; i < 2; i++)
        lanes[i] = !globalWrN || (!byteWrEnN && !laneSelN[i]);
    if (acc && lanes != 0) begin
      if (lanes[0]) refMem[eff][8:0]  = wrData[8:0];
      if (lanes[1]) refMem[eff][17:9] = wrData[17:9];
      mValid = 0;
    end else if (acc) begin
      mRd = refMem[eff]; mValid = 1; mFirst = !wasActive;
    end else mValid = 0;
  endtask

  task automatic compare();
    bit expDrive;
    logic [17:0] expData;
    expDrive = mValid && !mFirst && !outEnN && !sleep;
    expData  = expDrive ? mRd : 18'h0;
    vectors++;
    if (rdDrive !== expDrive || rdData !== expData) begin
      misses++;
      $display("FAIL %s: rdDrive=%0b rdData=%05h expected rdDrive=%0b rdData=%05h",
               tag, rdDrive, rdData, expDrive, expData);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    selN1 = 0; sel2 = 1; selN3 = 0; strobeCpuN = 1; strobeCtlN = 1;
    advanceN = 1; globalWrN = 1; byteWrEnN = 1; laneSelN = 2'b11;
    outEnN = 0; sleep = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    idle(); addrIn = 0; wrData = 0; rstN = 0;
    @(negedge clk);
    cycle(); cycle();
    tag = "R2"; compare();           // reset state: nothing driven
    rstN = 1;

    // R7: preload every word through controller strobe with global write
    tag = "R7";
    for (int a = 0; a < DEPTH; a++) begin
      strobeCtlN = 0; addrIn = a[ADDR_W-1:0];
      globalWrN = 0; byteWrEnN = 1; laneSelN = 2'b11;
      wrData = 18'((a * 1237 + 91) ^ (a << 9));
      cycle();
    end
    idle(); strobeCtlN = 0; sel2 = 0; cycle();   // R2 deselect
    idle(); tag = "R2"; advanceN = 0; cycle(); cycle();

    // R11 + R1 + R9: first read after deselect is masked
    idle(); tag = "R11"; strobeCpuN = 0; addrIn = 8'h21; cycle();
    // R5: wrap from offset 1 -> 2,3,0,1
    idle(); tag = "R5"; advanceN = 0;
    for (int k = 0; k < 4; k++) cycle();
    // R6: hold address
    idle(); tag = "R6"; cycle(); cycle();
    // R10: output enable high
    tag = "R10"; outEnN = 1; cycle(); outEnN = 0; tag = "R9"; cycle();

    // R3: both strobes plus global write -> read only
    idle(); tag = "R3"; strobeCpuN = 0; strobeCtlN = 0; addrIn = 8'h40;
    globalWrN = 0; wrData = 18'h3ffff; cycle();
    idle(); strobeCtlN = 0; addrIn = 8'h40; cycle(); cycle();

    // R4: processor strobe ignored while selN1 high, burst continues
    idle(); tag = "R4"; selN1 = 1; strobeCpuN = 0; advanceN = 0; cycle();
    idle(); tag = "R4"; cycle();

    // R8: byte writes
    idle(); tag = "R8"; strobeCtlN = 0; addrIn = 8'h62; byteWrEnN = 0;
    laneSelN = 2'b10; wrData = 18'h2a_155; cycle();
    idle(); byteWrEnN = 0; laneSelN = 2'b01; wrData = 18'h1c_0aa; cycle();
    idle(); byteWrEnN = 1; laneSelN = 2'b00; wrData = 18'h0; cycle(); cycle();
    idle(); strobeCtlN = 0; addrIn = 8'h62; cycle(); cycle();

    // R12: sleep with activity on inputs
    idle(); tag = "R12"; sleep = 1; strobeCtlN = 0; globalWrN = 0;
    addrIn = 8'h62; wrData = 18'h0;
    for (int k = 0; k < 3; k++) cycle();
    idle(); advanceN = 0; cycle(); cycle();
    idle(); strobeCtlN = 0; addrIn = 8'h62; cycle(); cycle();

    // R1: random traffic
    tag = "R1";
    for (int k = 0; k < 2000; k++) begin
      selN1      = ($urandom % 10) == 0;
      sel2       = ($urandom % 10) != 0;
      selN3      = ($urandom % 12) == 0;
      strobeCpuN = ($urandom % 4) != 0;
      strobeCtlN = ($urandom % 4) != 0;
      advanceN   = $urandom % 2;
      globalWrN  = ($urandom % 6) != 0;
      byteWrEnN  = ($urandom % 3) != 0;
      laneSelN   = 2'($urandom);
      wrData     = 18'($urandom);
      addrIn     = ADDR_W'($urandom);
      outEnN     = ($urandom % 5) == 0;
      sleep      = ($urandom % 15) == 0;
      cycle();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule